// File: doc/BRIEF.md
# Arithmetic Status Flag Unit

This block keeps the 16-bit status word that sits beside an arithmetic/logic datapath. Each time the datapath completes an operation it presents the operation class, the operand width, both operands, the result and the carry-out, with a one-cycle valid strobe. On the next clock edge the unit updates carry, parity, half-carry, zero, sign and overflow. Each of these flags is evaluated only over the active width of 8, 16 or 32 bits.

Three mode bits (string direction, interrupt enable and single-step trap) are not touched by operations. Separate set and clear strobes drive them, and they are held between strobes.

The operation class selects how each flag is formed. There are four classes: ADD, SUB, LOGIC and SHIFT.
- The carry comes from the datapath for ADD and SHIFT. For SHIFT it is the last bit shifted out.
- For SUB the unit computes the carry itself, as a borrow.
- LOGIC clears carry and overflow.
- SHIFT and LOGIC both leave the half-carry unchanged. SHIFT also leaves overflow unchanged.

Top module: `alu_status_flags`

## Requirements
- R1: After reset the status word reads 16'h0000.
- R2: Bits 1, 3, 5, 12, 13, 14 and 15 of the status word always read 0.
- R3: On an update, zero (bit 6) is 1 exactly when the result, masked to the active width, is zero. Width code 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits.
- R4: On an update, sign (bit 7) equals result bit 7, 15 or 31 for the 8-, 16- or 32-bit width.
- R5: On an update, parity (bit 2) is 1 when the masked result has an odd number of 1 bits, and 0 when the count is even.
- R6: Carry (bit 0) takes the carry_out input for ADD (class 0) and SHIFT (class 3). For SUB (class 1) it is 1 when the masked minuend is unsigned-less than the masked subtrahend.
- R7: For ADD, overflow (bit 11) is set when both operand signs are equal and differ from the result sign. For SUB, it is set when the operand signs differ and the result sign differs from the minuend sign. Signs are taken at the active width.
- R8: For ADD and SUB, half-carry (bit 4) equals bit 4 of (a XOR b XOR result).
- R9: LOGIC (class 2) clears carry and overflow and keeps half-carry. SHIFT keeps half-carry and overflow.
- R10: Direction (bit 10), interrupt enable (bit 9) and trap (bit 8) are set by their set strobes and cleared by their clear strobes. Clear wins when both strobes are high. Each bit holds otherwise, and operations never change them.
- R11: When op_valid is low, bits 0, 2, 4, 6, 7 and 11 hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation completed this cycle |
| op_class | input | 2 | 0 ADD, 1 SUB, 2 LOGIC, 3 SHIFT |
| op_width | input | 2 | 0 = 8, 1 = 16, 2/3 = 32 bits |
| opnd_a | input | 32 | First operand (minuend for SUB) |
| opnd_b | input | 32 | Second operand |
| alu_result | input | 32 | Datapath result |
| carry_out | input | 1 | Datapath carry, or last bit shifted out |
| dir_set | input | 1 | Set direction bit |
| dir_clr | input | 1 | Clear direction bit |
| ie_set | input | 1 | Set interrupt-enable bit |
| ie_clr | input | 1 | Clear interrupt-enable bit |
| trap_set | input | 1 | Set trap bit |
| trap_clr | input | 1 | Clear trap bit |
| status_word | output | 16 | Registered status word |

## Verification
Random operands with random width and class are applied to the unit. Additions and subtractions test the unit's signed-overflow and borrow rules against the datapath carry. Directed corner cases separate the width-masking logic from full-word evaluation:
- 8'h7F+1 and 16'h8000-1 show whether the sign and overflow are taken at the right bit.
- Zero results with nonzero upper bits test the width masking.
- Equal operands in a subtraction test the borrow.

Logic and shift operations that follow an arithmetic one show which flags persist. Idle cycles with garbage inputs, and mode strobes issued during operations, show that the groups of bits stay independent.

// File: rtl/flagu_pkg.sv
package flagu_pkg;

    typedef enum logic [1:0] {
        OPC_ADD   = 2'd0,
        OPC_SUB   = 2'd1,
        OPC_LOGIC = 2'd2,
        OPC_SHIFT = 2'd3
    } op_class_t;

    localparam int POS_CF   = 0;
    localparam int POS_PF   = 2;
    localparam int POS_AF   = 4;
    localparam int POS_ZF   = 6;
    localparam int POS_SF   = 7;
    localparam int POS_TF   = 8;
    localparam int POS_IE   = 9;
    localparam int POS_DF   = 10;
    localparam int POS_OF   = 11;
    localparam int STATUS_W = 16;

endpackage

// File: rtl/flagu_width_view.sv
module flagu_width_view #(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        width_sel,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic [DATA_W-1:0] r_in,
    output logic [DATA_W-1:0] a_m,
    output logic [DATA_W-1:0] b_m,
    output logic [DATA_W-1:0] r_m,
    output logic              sign_a,
    output logic              sign_b,
    output logic              sign_r
);
    localparam int MSB8  = 7;
    localparam int MSB16 = 15;
    localparam int MSBW  = DATA_W - 1;

    logic [DATA_W-1:0] mask;

    always_comb begin
        unique case (width_sel)
            2'd0:    mask = DATA_W'({8{1'b1}});
            2'd1:    mask = DATA_W'({16{1'b1}});
            default: mask = {DATA_W{1'b1}};
        endcase
        a_m = a_in & mask;
        b_m = b_in & mask;
        r_m = r_in & mask;
        unique case (width_sel)
            2'd0: begin
                sign_a = a_in[MSB8];
                sign_b = b_in[MSB8];
                sign_r = r_in[MSB8];
            end
            2'd1: begin
                sign_a = a_in[MSB16];
                sign_b = b_in[MSB16];
                sign_r = r_in[MSB16];
            end
            default: begin
                sign_a = a_in[MSBW];
                sign_b = b_in[MSBW];
                sign_r = r_in[MSBW];
            end
        endcase
    end
endmodule

// File: rtl/flagu_parity.sv
module flagu_parity #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] value,
    output logic              odd
);
    logic [DATA_W:0] chain;
    assign chain[0] = 1'b0;

    genvar gi;
    generate
        for (gi = 0; gi < DATA_W; gi++) begin : g_xor
            assign chain[gi+1] = chain[gi] ^ value[gi];
        end
    endgenerate

    assign odd = chain[DATA_W];
endmodule

// File: rtl/flagu_arith_eval.sv
module flagu_arith_eval
    import flagu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  op_class_t         op_cls,
    input  logic [DATA_W-1:0] a_m,
    input  logic [DATA_W-1:0] b_m,
    input  logic [DATA_W-1:0] r_m,
    input  logic              sign_a,
    input  logic              sign_b,
    input  logic              sign_r,
    input  logic              carry_in,
    output logic              cf_new,
    output logic              of_new,
    output logic              af_new,
    output logic              of_upd,
    output logic              af_upd
);
    localparam int HALF_BIT = 4;

    logic [DATA_W-1:0] sum_xor;
    assign sum_xor = a_m ^ b_m ^ r_m;

    always_comb begin
        cf_new = 1'b0;
        of_new = 1'b0;
        af_new = sum_xor[HALF_BIT];
        of_upd = 1'b1;
        af_upd = 1'b1;
        unique case (op_cls)
            OPC_ADD: begin
                cf_new = carry_in;
                of_new = (sign_a == sign_b) && (sign_r != sign_a);
            end
            OPC_SUB: begin
                cf_new = (a_m < b_m);
                of_new = (sign_a != sign_b) && (sign_r != sign_a);
            end
            OPC_LOGIC: begin
                af_upd = 1'b0;
            end
            OPC_SHIFT: begin
                cf_new = carry_in;
                of_upd = 1'b0;
                af_upd = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/alu_status_flags.sv
module alu_status_flags
    import flagu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        op_valid,
    input  logic [1:0]  op_class,
    input  logic [1:0]  op_width,
    input  logic [31:0] opnd_a,
    input  logic [31:0] opnd_b,
    input  logic [31:0] alu_result,
    input  logic        carry_out,
    input  logic        dir_set,
    input  logic        dir_clr,
    input  logic        ie_set,
    input  logic        ie_clr,
    input  logic        trap_set,
    input  logic        trap_clr,
    output logic [15:0] status_word
);
    logic [DATA_W-1:0] a_m, b_m, r_m;
    logic              sign_a, sign_b, sign_r;
    logic              par_odd;
    logic              cf_new, of_new, af_new, of_upd, af_upd;
    op_class_t         op_cls;

    logic cf_q, pf_q, af_q, zf_q, sf_q, of_q;
    logic tf_q, ie_q, df_q;

    assign op_cls = op_class_t'(op_class);

    flagu_width_view #(.DATA_W(DATA_W)) u_view (
        .width_sel (op_width),
        .a_in      (opnd_a),
        .b_in      (opnd_b),
        .r_in      (alu_result),
        .a_m       (a_m),
        .b_m       (b_m),
        .r_m       (r_m),
        .sign_a    (sign_a),
        .sign_b    (sign_b),
        .sign_r    (sign_r)
    );

    flagu_parity #(.DATA_W(DATA_W)) u_par (
        .value (r_m),
        .odd   (par_odd)
    );

    flagu_arith_eval #(.DATA_W(DATA_W)) u_eval (
        .op_cls   (op_cls),
        .a_m      (a_m),
        .b_m      (b_m),
        .r_m      (r_m),
        .sign_a   (sign_a),
        .sign_b   (sign_b),
        .sign_r   (sign_r),
        .carry_in (carry_out),
        .cf_new   (cf_new),
        .of_new   (of_new),
        .af_new   (af_new),
        .of_upd   (of_upd),
        .af_upd   (af_upd)
    );

    // Result-dependent flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cf_q <= 1'b0;
            pf_q <= 1'b0;
            af_q <= 1'b0;
            zf_q <= 1'b0;
            sf_q <= 1'b0;
            of_q <= 1'b0;
        end else if (op_valid) begin
            cf_q <= cf_new;
            pf_q <= par_odd;
            zf_q <= (r_m == '0);
            sf_q <= sign_r;
            if (af_upd) af_q <= af_new;
            if (of_upd) of_q <= of_new;
        end
    end

    // Mode bits: clear has priority over set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tf_q <= 1'b0;
            ie_q <= 1'b0;
            df_q <= 1'b0;
        end else begin
            if (trap_clr)     tf_q <= 1'b0;
            else if (trap_set) tf_q <= 1'b1;
            if (ie_clr)       ie_q <= 1'b0;
            else if (ie_set)  ie_q <= 1'b1;
            if (dir_clr)      df_q <= 1'b0;
            else if (dir_set) df_q <= 1'b1;
        end
    end

    always_comb begin
        status_word         = '0;
        status_word[POS_CF] = cf_q;
        status_word[POS_PF] = pf_q;
        status_word[POS_AF] = af_q;
        status_word[POS_ZF] = zf_q;
        status_word[POS_SF] = sf_q;
        status_word[POS_TF] = tf_q;
        status_word[POS_IE] = ie_q;
        status_word[POS_DF] = df_q;
        status_word[POS_OF] = of_q;
    end

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word & 16'hF02A) == 16'h0000);

    assert_zero_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (status_word[POS_ZF] == ($past(r_m) == '0)));

    assert_logic_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_cls == OPC_LOGIC) |=> (!status_word[POS_CF] && !status_word[POS_OF]));

    assert_logic_keeps_af_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_cls == OPC_LOGIC) |=> $stable(status_word[POS_AF]));

    assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_clr || ie_clr || trap_clr) |=>
            ((!$past(dir_clr) || !status_word[POS_DF]) &&
             (!$past(ie_clr) || !status_word[POS_IE]) &&
             (!$past(trap_clr) || !status_word[POS_TF])));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(status_word[7:0]) && $stable(status_word[POS_OF]));

endmodule

// File: tb/alu_status_flags_bench.sv
`timescale 1ns/1ps
module alu_status_flags_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [1:0]  op_class, op_width;
    logic [31:0] opnd_a, opnd_b, alu_result;
    logic        carry_out;
    logic        dir_set, dir_clr, ie_set, ie_clr, trap_set, trap_clr;
    logic [15:0] status_word;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // expected model
    logic e_cf, e_pf, e_af, e_zf, e_sf, e_of, e_tf, e_ie, e_df;

    always #2.5 clk = ~clk;

    alu_status_flags u_alu_status_flags (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_class(op_class),
        .op_width(op_width), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .alu_result(alu_result), .carry_out(carry_out),
        .dir_set(dir_set), .dir_clr(dir_clr), .ie_set(ie_set), .ie_clr(ie_clr),
        .trap_set(trap_set), .trap_clr(trap_clr), .status_word(status_word)
    );

    function automatic logic [31:0] wmask(input logic [1:0] w);
        if (w == 2'd0) return 32'h0000_00FF;
        if (w == 2'd1) return 32'h0000_FFFF;
        return 32'hFFFF_FFFF;
    endfunction

    function automatic logic wsign(input logic [1:0] w, input logic [31:0] v);
        if (w == 2'd0) return v[7];
        if (w == 2'd1) return v[15];
        return v[31];
    endfunction

    task automatic check(input string req, input string what, input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
        end
    endtask

    task automatic check_word(input string tag);
        logic [15:0] e;
        e = 16'h0;
        e[0] = e_cf; e[2] = e_pf; e[4] = e_af; e[6] = e_zf; e[7] = e_sf;
        e[8] = e_tf; e[9] = e_ie; e[10] = e_df; e[11] = e_of;
        check("R2", {tag, " reserved"}, (status_word & 16'hF02A) != 0, 1'b0);
        check("R6", {tag, " carry"},    status_word[0],  e[0]);
        check("R5", {tag, " parity"},   status_word[2],  e[2]);
        check("R8", {tag, " halfcarry"},status_word[4],  e[4]);
        check("R3", {tag, " zero"},     status_word[6],  e[6]);
        check("R4", {tag, " sign"},     status_word[7],  e[7]);
        check("R7", {tag, " overflow"}, status_word[11], e[11]);
        check("R10",{tag, " modes"},    status_word[10:8] == e[10:8], 1'b1);
    endtask

    task automatic model_modes;
        if (trap_clr) e_tf = 0; else if (trap_set) e_tf = 1;
        if (ie_clr)   e_ie = 0; else if (ie_set)   e_ie = 1;
        if (dir_clr)  e_df = 0; else if (dir_set)  e_df = 1;
    endtask

    // called at a negedge; returns at the following negedge after checking
    task automatic apply(input logic [1:0] cls, input logic [1:0] w,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] r, input logic co, input string tag);
        logic [31:0] am, bm, rm;
        logic sa, sb, sr;
        op_valid = 1; op_class = cls; op_width = w;
        opnd_a = a; opnd_b = b; alu_result = r; carry_out = co;
        am = a & wmask(w); bm = b & wmask(w); rm = r & wmask(w);
        sa = wsign(w, a); sb = wsign(w, b); sr = wsign(w, r);
        e_zf = (rm == 0);
        e_sf = sr;
        e_pf = ($countones(rm) % 2) == 1;
        case (cls)
            2'd0: begin e_cf = co; e_of = (sa == sb) && (sr != sa); e_af = (am ^ bm ^ rm) >> 4; end
            2'd1: begin e_cf = am < bm; e_of = (sa != sb) && (sr != sa); e_af = (am ^ bm ^ rm) >> 4; end
            2'd2: begin e_cf = 0; e_of = 0; end
            default: begin e_cf = co; end
        endcase
        model_modes();
        @(negedge clk);
        op_valid = 0;
        dir_set = 0; dir_clr = 0; ie_set = 0; ie_clr = 0; trap_set = 0; trap_clr = 0;
        check_word(tag);
    endtask

    task automatic do_add(input logic [1:0] w, input logic [31:0] a, input logic [31:0] b, input string tag);
        logic [32:0] s;
        logic [31:0] m;
        m = wmask(w);
        s = {1'b0, a & m} + {1'b0, b & m};
        apply(2'd0, w, a, b, s[31:0] & m, (w == 2'd0) ? s[8] : (w == 2'd1) ? s[16] : s[32], tag);
    endtask

    task automatic do_sub(input logic [1:0] w, input logic [31:0] a, input logic [31:0] b, input string tag);
        apply(2'd1, w, a, b, ((a & wmask(w)) - (b & wmask(w))) & wmask(w), $urandom_range(0, 1), tag);
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_1234);
        rst_n = 0; op_valid = 0; op_class = 0; op_width = 0;
        opnd_a = 0; opnd_b = 0; alu_result = 0; carry_out = 0;
        dir_set = 0; dir_clr = 0; ie_set = 0; ie_clr = 0; trap_set = 0; trap_clr = 0;
        {e_cf, e_pf, e_af, e_zf, e_sf, e_of, e_tf, e_ie, e_df} = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        n_checks++;
        if (status_word !== 16'h0000) begin
            n_fail++;
            $display("FAIL R1 reset word: got %h expected 0000", status_word);
        end
        rst_n = 1;
        @(negedge clk);

        // directed corners
        do_add(2'd0, 32'hFFFF_FF7F, 32'h0000_0001, "R7 add8 0x7F+1");
        do_add(2'd0, 32'h0000_00FF, 32'h0000_0001, "R6 add8 carry, R3 zero");
        apply(2'd2, 2'd0, 32'h0, 32'h0, 32'hABCD_1200, 1'b1, "R9 logic after arith, R3 masked zero");
        do_sub(2'd1, 32'h0000_8000, 32'h0000_0001, "R7 sub16 0x8000-1");
        do_sub(2'd2, 32'h1234_5678, 32'h1234_5678, "R6 sub equal no borrow");
        do_sub(2'd2, 32'h0000_0001, 32'h0000_0002, "R6 sub borrow");
        do_add(2'd1, 32'h0000_000F, 32'h0000_0001, "R8 half carry");
        apply(2'd3, 2'd2, 32'h8000_0000, 32'h0, 32'h0, 1'b1, "R9 shift keeps af/of");
        do_add(2'd3, 32'h7FFF_FFFF, 32'h1, "R4 add32 width code 3");

        // modes: set all, then both set and clear
        dir_set = 1; ie_set = 1; trap_set = 1;
        do_add(2'd0, 32'h3, 32'h4, "R10 set modes");
        dir_set = 1; dir_clr = 1; ie_clr = 1; trap_set = 1;
        apply(2'd2, 2'd1, 32'h0, 32'h0, 32'h0000_0101, 1'b0, "R10 clear wins");

        // R11 idle: garbage inputs, no valid
        op_class = 2'd1; op_width = 2'd0; opnd_a = 32'h1; opnd_b = 32'h2;
        alu_result = 32'h0; carry_out = 1;
        @(negedge clk);
        check_word("R11 idle hold");

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [1:0] w, c;
            logic [31:0] a, b;
            w = 2'($urandom_range(0, 3));
            c = 2'($urandom_range(0, 3));
            a = $urandom; b = $urandom;
            dir_set = ($urandom_range(0, 7) == 0); dir_clr = ($urandom_range(0, 7) == 0);
            ie_set = ($urandom_range(0, 7) == 0);  ie_clr = ($urandom_range(0, 7) == 0);
            trap_set = ($urandom_range(0, 7) == 0); trap_clr = ($urandom_range(0, 7) == 0);
            case (c)
                2'd0: do_add(w, a, b, "rand add");
                2'd1: do_sub(w, a, b, "rand sub");
                2'd2: apply(2'd2, w, a, b, a ^ b, $urandom_range(0, 1), "rand logic R9");
                default: apply(2'd3, w, a, b, a << 1, wsign(w, a), "rand shift R9");
            endcase
            if ($urandom_range(0, 9) == 0) begin
                alu_result = $urandom; opnd_a = $urandom;
                @(negedge clk);
                check_word("R11 rand idle");
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule